// File: doc/BRIEF.md
# Interrupt Claim Controller

This block gathers up to 31 interrupt lines into one request line for a processor. Each line sets a sticky pending flag. Software reads those flags, masks them with an enable word, and services one line at a time through a single claim/complete register. A read of that register names the lowest-numbered line that is both pending and enabled. A write of a line number retires that line and clears its flag. Line numbers start at 1, so bit n of every mask word stands for line n+1. The value 0 means "nothing to claim".

Each line is either edge-captured or level-captured, chosen per line by a parameter mask.

- **Edge line:** the flag is set by a low-to-high transition. It then stays set until it is completed.
- **Level line:** the flag is re-armed on every cycle in which the input is high. Completing such a line therefore only takes effect once the input has dropped.

When a completion and a new set arrive in the same cycle, the set wins.

Register access is a single-cycle request port, and every request is accepted on the cycle it is presented. A read answers one cycle later with a response-valid pulse and its data. The port has no back-pressure, so the requester must be able to take a response on every cycle after a read. Offsets that are not mapped or are not word-aligned read as 0xDEAD_BEEF, and writes to them are dropped.

Top module: `irq_claim_ctrl`

## Requirements
- R1: A read of offset 0x00 returns 0x1C00_0001. Every read's data is on `rsp_rdata_o` in the cycle after the request, qualified by `rsp_valid_o` high for exactly that cycle. Writes never produce a response.
- R2: For an edge line (mask bit set), a clock edge at which `src_i[n]` is 1 and was 0 at the previous edge sets pending bit n. The bit stays set after the input falls. Offset 0x04 reads the pending bits, with bit n standing for line n+1.
- R3: For a level line (mask bit clear), every edge with `src_i[n]` high sets pending bit n. A completion of that line while the input is still high leaves the bit set. After the input falls, a completion clears the bit.
- R4: Offset 0x08 is the enable word and is read/write. Bits at or above NUM_SRC are not stored and read as 0.
- R5: A read of offset 0x0C returns the smallest ID k such that pending bit k-1 and enable bit k-1 are both 1. It returns 0 when no such k exists. This read changes no pending bit.
- R6: A write of value k (1..NUM_SRC, upper bits zero) to offset 0x0C clears pending bit k-1. If that same edge also sets bit k-1, the bit stays set.
- R7: A write to offset 0x0C whose value is 0, or is larger than NUM_SRC, changes no pending bit.
- R8: `irq_o` is 1 exactly when some line is both pending and enabled. It follows register updates in the cycle after the edge that made them.
- R9: Reads of offsets other than 0x00/0x04/0x08/0x0C, or of a non-word-aligned address, return 0xDEAD_BEEF. Writes to such addresses, and writes to 0x00 or 0x04, change nothing.
- R10: After reset, pending and enable are all zero, `irq_o` is 0 and `rsp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt lines, synchronous to clk; bit n is line n+1 |
| req_valid_i | input | 1 | Register request present; always accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset within the 4 KiB window |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
Two corner cases are the hardest to reach from the ports, because each depends on two events landing on the same clock edge:
- a completion write arriving in the very cycle that a fresh rising edge re-sets the same line;
- a completion of a level line that is still asserted.

The bench drives the line's transition and the completion write from the same falling edge, so both are sampled together. It then reads the pending word back to confirm the set prevailed. Invalid completion values (0, 32 and a value with upper bits set) are issued while other lines are pending, so an unintended clear would show in the next pending read.

// File: rtl/irq_claim_pkg.sv
package irq_claim_pkg;
  localparam logic [31:0] ID_VALUE  = 32'h1C00_0001;
  localparam logic [31:0] BAD_VALUE = 32'hDEAD_BEEF;
  localparam int OFF_IDENT   = 'h00;
  localparam int OFF_PEND    = 'h04;
  localparam int OFF_ENABLE  = 'h08;
  localparam int OFF_CLAIM   = 'h0C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IDENT,
    SEL_PEND,
    SEL_ENABLE,
    SEL_CLAIM
  } reg_sel_e;
endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int NUM_SRC = 31,
  parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] set_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_i;
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_line
    if (EDGE_MASK[n]) begin : g_edge
      assign set_w[n] = src_i[n] & ~src_q[n];
      // R2
      edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[n] && !src_q[n]) |=> pend_o[n]);
    end else begin : g_level
      assign set_w[n] = src_i[n];
      // R3
      level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_i[n] |=> pend_o[n]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_o[n] <= 1'b0;
      else if (set_w[n])  pend_o[n] <= 1'b1;
      else if (clr_i[n])  pend_o[n] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_SRC = 31,
  localparam int ID_W = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [ID_W-1:0]    id_o
);
  logic [NUM_SRC-1:0] live;
  assign live = pend_i & en_i;

  always_comb begin
    id_o = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (live[n]) id_o = ID_W'(n + 1);
    end
  end
endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl #(
  parameter int NUM_SRC = 31,
  parameter int ADDR_W = 12,
  parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [31:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [31:0]        rsp_rdata_o,
  output logic               irq_o
);
  import irq_claim_pkg::*;
  localparam int ID_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] clr;
  logic [ID_W-1:0]    claim_id;
  reg_sel_e           sel;
  logic [31:0]        rd_mux;
  logic               wr_claim;

  always_comb begin
    sel = SEL_NONE;
    if (req_addr_i == ADDR_W'(OFF_IDENT))       sel = SEL_IDENT;
    else if (req_addr_i == ADDR_W'(OFF_PEND))   sel = SEL_PEND;
    else if (req_addr_i == ADDR_W'(OFF_ENABLE)) sel = SEL_ENABLE;
    else if (req_addr_i == ADDR_W'(OFF_CLAIM))  sel = SEL_CLAIM;
  end

  assign wr_claim = req_valid_i && req_write_i && (sel == SEL_CLAIM);

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_clr
    assign clr[n] = wr_claim && (req_wdata_i == 32'(n + 1));
  end

  irq_src_gate #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend_i (pend),
    .en_i   (en_q),
    .id_o   (claim_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (req_valid_i && req_write_i && sel == SEL_ENABLE)
      en_q <= req_wdata_i[NUM_SRC-1:0];
  end

  always_comb begin
    case (sel)
      SEL_IDENT:  rd_mux = ID_VALUE;
      SEL_PEND:   rd_mux = 32'(pend);
      SEL_ENABLE: rd_mux = 32'(en_q);
      SEL_CLAIM:  rd_mux = 32'(claim_id);
      default:    rd_mux = BAD_VALUE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && !req_write_i;
      if (req_valid_i && !req_write_i) rsp_rdata_o <= rd_mux;
    end
  end

  assign irq_o = |(pend & en_q);

  // R5
  claim_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_id != '0) |-> (pend[claim_id - 1'b1] && en_q[claim_id - 1'b1]));
  // R7
  bad_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && req_addr_i == ADDR_W'(OFF_CLAIM) &&
     (req_wdata_i == 32'd0 || req_wdata_i > 32'(NUM_SRC)))
    |=> (($past(pend) & ~pend) == '0));
  // R9
  unaligned_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i && req_addr_i[1:0] != 2'b00)
    |=> (rsp_rdata_o == BAD_VALUE));
  // R1
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i));
endmodule

// File: tb/irq_claim_ctrl_bench.sv
`timescale 1ns/1ps
module irq_claim_ctrl_bench;
  localparam int NS = 31;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          irq;

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_claim_ctrl #(.NUM_SRC(NS), .ADDR_W(AW), .EDGE_MASK(32'h0000_FFFF)) u_irq_claim_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  // monitor: pops the expected value for each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      applied++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R1 unexpected response: actual %h expected none", rsp_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          miscompares++;
          $display("FAIL %s read: actual %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic set_src(input int n, input logic v);
    @(negedge clk);
    src[n] = v;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    applied++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s irq: actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    applied++;
    if (rsp_valid !== 1'b0 || irq !== 1'b0) begin
      miscompares++;
      $display("FAIL R10 reset outputs: actual %b%b expected 00", rsp_valid, irq);
    end
    rst_n = 1'b1;
    rd(12'h000, 32'h1C00_0001, "R1");
    rd(12'h004, 32'h0, "R10 pending");
    rd(12'h008, 32'h0, "R10 enable");
    rd(12'h00C, 32'h0, "R10/R5 claim empty");
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, 32'h7FFF_FFFF, "R4");
    chk_irq(1'b0, "R8 idle");
    // edge lines 5 and 3 (bits 4, 2)
    set_src(4, 1'b1); set_src(4, 1'b0);
    set_src(2, 1'b1); set_src(2, 1'b0);
    rd(12'h004, 32'h0000_0014, "R2");
    rd(12'h00C, 32'd3, "R5 lowest");
    rd(12'h004, 32'h0000_0014, "R5 no side effect");
    chk_irq(1'b1, "R8 active");
    wr(12'h00C, 32'd3);
    rd(12'h00C, 32'd5, "R6 complete");
    wr(12'h00C, 32'd0);
    wr(12'h00C, 32'd32);
    wr(12'h00C, 32'h0000_0105);
    rd(12'h004, 32'h0000_0010, "R7");
    wr(12'h008, 32'h0000_0000);
    chk_irq(1'b0, "R8 masked");
    rd(12'h00C, 32'd0, "R5 masked");
    wr(12'h008, 32'h0000_0010);
    wr(12'h00C, 32'd5);
    chk_irq(1'b0, "R8 completed");
    // level line 20 (bit 19)
    set_src(19, 1'b1);
    wr(12'h00C, 32'd20);
    rd(12'h004, 32'h0008_0000, "R3 held high");
    set_src(19, 1'b0);
    wr(12'h00C, 32'd20);
    rd(12'h004, 32'h0, "R3 cleared");
    // set wins: line 1 pending, completion on the same edge as a new rise
    set_src(0, 1'b1); set_src(0, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h00C; req_wdata = 32'd1;
    src[0] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; src[0] = 1'b0;
    rd(12'h004, 32'h0000_0001, "R6 set wins");
    // unmapped and ignored
    rd(12'h010, 32'hDEAD_BEEF, "R9 unmapped");
    rd(12'h00A, 32'hDEAD_BEEF, "R9 unaligned");
    rd(12'h80C, 32'hDEAD_BEEF, "R9 high offset");
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h000, 32'h0);
    wr(12'h009, 32'h0);
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h004, 32'h0000_0001, "R9 pending write ignored");
    rd(12'h008, 32'h0000_0010, "R9 enable untouched");
    rd(12'h000, 32'h1C00_0001, "R9 ident untouched");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R1 missing responses: actual %0d outstanding expected 0", exp_q.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule